// File: doc/BRIEF.md
# Pipelined Converter Code Corrector

This block sits behind the four flash comparator banks of a 12-bit pipelined analog-to-digital converter. It merges their raw decisions into one straight-binary sample word. The stages resolve one sample in turn, one clock apart, so the block holds the codes of the earlier stages in short delay lines. When the last stage's code for a sample arrives, all four codes of that sample are present in the same cycle. They are summed with overlapping bit weights. Each redundant stage loses half an LSB of its own weight to an offset correction, so a comparator that decides one step too high or too low in an early stage is absorbed by the stages after it.

The corrected sum is clamped to the 12-bit range and registered together with an over-range flag. When the flag is set, the word's MSB tells the two cases apart: 1 means the input was above full scale and 0 means it was below zero. The block accepts a new sample on every clock. The stream has no back-pressure. There is no ready signal, the converter never stalls, and the consumer must take the word in every cycle where `res_vld` is high. `res_vld` is low after reset and rises once the pipeline holds a complete sample.

Top module: `pipe_adc_corrector`

## Requirements
- R1: While `rst` is high at a rising clock edge, all delay lines and outputs clear: after that edge `res_word` is 0, `res_ovr` is 0 and `res_vld` is 0.
- R2: After reset is released, `res_vld` stays low through the first three rising edges. It goes high after the fourth edge and stays high until the next reset.
- R3: The word produced at edge n combines the stage-1 code captured at edge n-3, the stage-2 code at edge n-2, the stage-3 code at edge n-1 and the stage-4 code at edge n. The codes `st1_code`..`st4_code` of one sample are therefore presented on consecutive cycles.
- R4: The corrected value is V = st1·256 + st2·32 + st3·8 + st4 − 148. The offset 148 is 128 + 16 + 4, which is half the weight of each of stages 1 to 3.
- R5: Code splits of the same value give the same word. For example, (8,0,0,0), (7,8,0,0) and (7,7,4,0) all give 1900.
- R6: If V < 0, then `res_word` = 0 and `res_ovr` = 1. The MSB is 0, which marks low overflow.
- R7: If V > 4095, then `res_word` = 4095 and `res_ovr` = 1. The MSB is 1, which marks high overflow.
- R8: If 0 ≤ V ≤ 4095, then `res_word` = V and `res_ovr` = 0. Both end points are included.
- R9: A new sample is taken on every clock with no stall. Back-to-back samples each yield exactly one valid word, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| st1_code | input | 5 | Stage-1 flash code (four effective bits plus one redundant bit) |
| st2_code | input | 4 | Stage-2 flash code, one cycle after stage 1 |
| st3_code | input | 4 | Stage-3 flash code, two cycles after stage 1 |
| st4_code | input | 3 | Final flash code, three cycles after stage 1 |
| res_vld | output | 1 | Output word valid; no back-pressure is possible |
| res_word | output | 12 | Corrected straight-binary sample |
| res_ovr | output | 1 | Over-range flag; MSB gives its direction |

## Verification
Two functions can act in the same cycle: the first assertion of `res_vld` and range clamping. The first sample after every reset is all-zero codes, so the first valid word is a low overflow (0 with the flag set), and its timing and its clamp are judged together. Reset and output update also collide: a reset is raised while several samples are still in the delay lines. The outputs must read all zero and not valid after it, and the words of the abandoned samples must never appear.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  // number of pipeline stages feeding the corrector
  localparam int NSTG = 4;
  // cycles from stage-1 capture to registered output
  localparam int LATENCY = NSTG - 1;
endpackage

// File: rtl/stage_delay.sv
module stage_delay #(
  parameter int W     = 4,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_chain
      logic [W-1:0] q [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) q[i] <= '0;
        end else begin
          q[0] <= din;
          for (int i = 1; i < DEPTH; i++) q[i] <= q[i-1];
        end
      end
      assign dout = q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/code_combiner.sv
module code_combiner #(
  parameter int W1    = 5,
  parameter int W2    = 4,
  parameter int W3    = 4,
  parameter int W4    = 3,
  parameter int SH1   = 8,
  parameter int SH2   = 5,
  parameter int SH3   = 3,
  parameter int SUM_W = 15
) (
  input  logic [W1-1:0]           c1,
  input  logic [W2-1:0]           c2,
  input  logic [W3-1:0]           c3,
  input  logic [W4-1:0]           c4,
  output logic signed [SUM_W-1:0] sum
);
  // half an LSB of each redundant stage's weight
  localparam int OFFSET = (1 << (SH1-1)) + (1 << (SH2-1)) + (1 << (SH3-1));

  logic [SUM_W-1:0] raw;

  always_comb begin
    raw = (SUM_W'(c1) << SH1) + (SUM_W'(c2) << SH2)
        + (SUM_W'(c3) << SH3) + SUM_W'(c4);
    sum = $signed(raw - SUM_W'(OFFSET));
  end
endmodule

// File: rtl/range_clamp.sv
module range_clamp #(
  parameter int OUT_W = 12,
  parameter int SUM_W = 15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [SUM_W-1:0] sum,
  output logic [OUT_W-1:0]        word,
  output logic                    ovr
);
  localparam int MAXC = (1 << OUT_W) - 1;
  localparam logic signed [SUM_W-1:0] MAXS = SUM_W'(MAXC);

  logic [OUT_W-1:0] word_d;
  logic             ovr_d;

  always_comb begin
    if (sum < 0) begin
      word_d = '0;
      ovr_d  = 1'b1;
    end else if (sum > MAXS) begin
      word_d = OUT_W'(MAXC);
      ovr_d  = 1'b1;
    end else begin
      word_d = sum[OUT_W-1:0];
      ovr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      ovr  <= 1'b0;
    end else begin
      word <= word_d;
      ovr  <= ovr_d;
    end
  end

  // R1
  clear_on_rst_chk: assert property (@(posedge clk)
    rst |=> (word == '0 && !ovr));
  // R6
  low_ovr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr && !word[OUT_W-1]) |-> (word == '0));
  // R7
  high_ovr_full_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr && word[OUT_W-1]) |-> (word == OUT_W'(MAXC)));
endmodule

// File: rtl/valid_tracker.sv
module valid_tracker #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst,
  output logic vld
);
  localparam int DEPTH = LAT + 1;

  logic [DEPTH-1:0] fill;

  always_ff @(posedge clk) begin
    if (rst) fill <= '0;
    else     fill <= {fill[DEPTH-2:0], 1'b1};
  end

  assign vld = fill[DEPTH-1];

  // R2
  vld_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    vld |=> vld);
  // R2
  vld_needs_fill_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vld) |-> fill[0]);
endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector #(
  parameter int ST1_W = 5,
  parameter int ST2_W = 4,
  parameter int ST3_W = 4,
  parameter int ST4_W = 3,
  parameter int SH1   = 8,
  parameter int SH2   = 5,
  parameter int SH3   = 3,
  parameter int OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ST1_W-1:0] st1_code,
  input  logic [ST2_W-1:0] st2_code,
  input  logic [ST3_W-1:0] st3_code,
  input  logic [ST4_W-1:0] st4_code,
  output logic             res_vld,
  output logic [OUT_W-1:0] res_word,
  output logic             res_ovr
);
  import adc_corr_pkg::*;

  // headroom for the top stage's redundant bit plus a sign bit
  localparam int SUM_W = OUT_W + 3;

  logic [ST1_W-1:0] a1;
  logic [ST2_W-1:0] a2;
  logic [ST3_W-1:0] a3;
  logic [ST4_W-1:0] a4;
  logic signed [SUM_W-1:0] sum;

  stage_delay #(.W(ST1_W), .DEPTH(LATENCY))     u_d1 (.clk(clk), .rst(rst), .din(st1_code), .dout(a1));
  stage_delay #(.W(ST2_W), .DEPTH(LATENCY - 1)) u_d2 (.clk(clk), .rst(rst), .din(st2_code), .dout(a2));
  stage_delay #(.W(ST3_W), .DEPTH(LATENCY - 2)) u_d3 (.clk(clk), .rst(rst), .din(st3_code), .dout(a3));
  stage_delay #(.W(ST4_W), .DEPTH(LATENCY - 3)) u_d4 (.clk(clk), .rst(rst), .din(st4_code), .dout(a4));

  code_combiner #(
    .W1(ST1_W), .W2(ST2_W), .W3(ST3_W), .W4(ST4_W),
    .SH1(SH1), .SH2(SH2), .SH3(SH3), .SUM_W(SUM_W)
  ) u_comb (.c1(a1), .c2(a2), .c3(a3), .c4(a4), .sum(sum));

  range_clamp #(.OUT_W(OUT_W), .SUM_W(SUM_W)) u_clamp (
    .clk(clk), .rst(rst), .sum(sum), .word(res_word), .ovr(res_ovr)
  );

  valid_tracker #(.LAT(LATENCY)) u_vld (.clk(clk), .rst(rst), .vld(res_vld));

  // R1
  vld_low_after_rst_chk: assert property (@(posedge clk)
    rst |=> !res_vld);
endmodule

// File: tb/tb_pipe_adc_corrector.sv
`timescale 1ns/1ps
module tb_pipe_adc_corrector;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic [4:0]  c1 = '0;
  logic [3:0]  c2 = '0;
  logic [3:0]  c3 = '0;
  logic [2:0]  c4 = '0;
  logic        vld;
  logic [11:0] word;
  logic        ovr;

  int n_chk = 0;
  int n_bad = 0;

  int s1q[$], s2q[$], s3q[$], s4q[$];
  string stag[$];
  logic [12:0] exq[$];
  string tagq[$];

  pipe_adc_corrector dut (
    .clk(clk), .rst(rst), .st1_code(c1), .st2_code(c2), .st3_code(c3),
    .st4_code(c4), .res_vld(vld), .res_word(word), .res_ovr(ovr)
  );

  // {flag, word} from the formula of R4 with the clamps of R6/R7/R8
  function automatic logic [12:0] expect_of(int a, int b, int c, int d);
    int v;
    v = a*256 + b*32 + c*8 + d - 148;
    if (v < 0)    return {1'b1, 12'd0};
    if (v > 4095) return {1'b1, 12'hFFF};
    return {1'b0, 12'(v)};
  endfunction

  task automatic check(string req, logic [12:0] act, logic [12:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%h expected=0x%h", req, act, exp);
    end
  endtask

  task automatic add(int a, int b, int c, int d, string tag);
    s1q.push_back(a); s2q.push_back(b); s3q.push_back(c); s4q.push_back(d);
    stag.push_back(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    c1 = '0; c2 = '0; c3 = '0; c4 = '0;
    repeat (3) @(negedge clk);
    check("R1 word/flag", {ovr, word}, 13'd0);
    check("R1 valid", {12'd0, vld}, 13'd0);
    rst = 1'b0;
  endtask

  // driver pushes expectations; the monitor part pops at each negedge
  task automatic run_block(int stop_at);
    int n;
    n = s1q.size();
    do_reset();
    for (int cyc = 0; cyc < n + 3; cyc++) begin
      if (cyc == stop_at) break;
      c1 = (cyc < n) ? 5'(s1q[cyc]) : '0;
      c2 = (cyc >= 1 && cyc - 1 < n) ? 4'(s2q[cyc-1]) : '0;
      c3 = (cyc >= 2 && cyc - 2 < n) ? 4'(s3q[cyc-2]) : '0;
      c4 = (cyc >= 3 && cyc - 3 < n) ? 3'(s4q[cyc-3]) : '0;
      if (cyc >= 3 && cyc - 3 < n) begin
        exq.push_back(expect_of(s1q[cyc-3], s2q[cyc-3], s3q[cyc-3], s4q[cyc-3]));
        tagq.push_back(stag[cyc-3]);
      end
      @(negedge clk);
      // R2: valid after the fourth edge since release
      check("R2 valid timing", {12'd0, vld}, {12'd0, (cyc + 1 >= 4)});
      if (vld) begin
        if (exq.size() == 0) begin
          check("R9 extra word", 13'd1, 13'd0);
        end else begin
          check(tagq.pop_front(), {ovr, word}, exq.pop_front());
        end
      end
    end
    if (stop_at < 0) check("R9 words outstanding", 13'(exq.size()), 13'd0);
    exq.delete(); tagq.delete();
    s1q.delete(); s2q.delete(); s3q.delete(); s4q.delete(); stag.delete();
  endtask

  initial begin
    // first sample is a low overflow, coinciding with valid onset
    add(0, 0, 0, 0, "R6 low overflow at valid onset");
    add(31, 15, 15, 7, "R7 high overflow");
    add(0, 4, 2, 4, "R8 lower edge 0");
    add(0, 4, 2, 3, "R6 one below zero");
    add(16, 4, 2, 3, "R8 upper edge 4095");
    add(16, 4, 2, 4, "R7 one above 4095");
    add(8, 0, 0, 0, "R5 split A");
    add(7, 8, 0, 0, "R5 split B");
    add(7, 7, 4, 0, "R5 split C");
    add(3, 9, 1, 6, "R4 mid value");
    add(12, 0, 15, 2, "R3 alignment");
    run_block(-1);

    // R9: long back-to-back random stream
    add(0, 0, 0, 0, "R6 onset");
    for (int i = 0; i < 300; i++)
      add($urandom_range(0, 31), $urandom_range(0, 15),
          $urandom_range(0, 15), $urandom_range(0, 7), "R4 random");
    run_block(-1);

    // R1: reset raised while samples are still in flight
    add(0, 0, 0, 0, "R6 onset");
    for (int i = 0; i < 10; i++) add(20, 3, 9, 5, "R3 in flight");
    run_block(6);

    // after the abort: a clean stream must not show the abandoned words
    add(0, 0, 0, 0, "R6 onset");
    add(10, 2, 5, 1, "R1 clean restart");
    add(5, 11, 3, 7, "R4 clean restart");
    run_block(-1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule